// File: doc/BRIEF.md
# Mesh Router With Column-First Routing

This block is one node of a two-dimensional mesh of tiles. Each mesh column and each mesh row is a half ring, which means it is unidirectional. The node has a local injection port, one input and one output on its column ring, one input and one output on its row ring, and a local ejection port. Every flit carries its destination column (X) and row (Y). The node compares these fields with its own fixed coordinates, which are set by parameters.

A flit travels along its column until it reaches the destination row. There it turns once onto the row ring and travels along the row to the destination tile. Traffic already on a ring always keeps moving. Arbitration happens only in two places: where a flit enters the mesh from the local port, and where a flit turns from the column onto the row. When a turning flit and a local injection compete, they alternate round-robin. All three outputs are registered. Every port uses a valid/ready handshake. With the default 3-bit coordinates the node addresses grids of up to 8 by 8, which covers a 36-tile mesh.

Top module: `mesh_yx_router`

## Requirements
- R1: While reset is high, and in the first cycle after reset, the column, row and ejection outputs are not valid.
- R2: A flit is {dst_y, dst_x, payload}, with payload in the low PAYLOAD_W bits, dst_x above it and dst_y at the top. An injected flit whose dst_y differs from MY_Y leaves on the column output. If dst_y matches and dst_x differs, it leaves on the row output. If both match, it leaves on the ejection output.
- R3: A flit arriving on the column input continues on the column output when dst_y differs from MY_Y. It turns to the row output when dst_y matches and dst_x differs. It is ejected when both match.
- R4: A flit arriving on the row input is ejected only when dst_x and dst_y both match the node. Otherwise it continues on the row output.
- R5: When a column-through flit and an injection bound for the column are offered in the same cycle, the column flit is accepted and the injection waits.
- R6: When a row-through flit competes for the row output with a turning flit, an injection, or both, the row flit is accepted and the others wait.
- R7: When a turning flit and an injection compete for a free row output, and no row-through flit is present, the grant alternates between them on every successive grant.
- R8: Ejection priority is row input first, then column input, then local injection.
- R9: A flit accepted at a clock edge appears on its output after that edge, and not before it.
- R10: While an output is valid and its ready is low, its flit stays unchanged and no new flit is accepted for that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid | input | 1 | Local flit offered |
| inj_ready | output | 1 | Local flit accepted this cycle |
| inj_flit | input | FLIT_W | Local flit |
| col_in_valid | input | 1 | Flit offered by the upstream column neighbour |
| col_in_ready | output | 1 | Column flit accepted |
| col_in_flit | input | FLIT_W | Column input flit |
| row_in_valid | input | 1 | Flit offered by the upstream row neighbour |
| row_in_ready | output | 1 | Row flit accepted |
| row_in_flit | input | FLIT_W | Row input flit |
| col_out_valid | output | 1 | Column output holds a flit |
| col_out_ready | input | 1 | Downstream column neighbour takes the flit |
| col_out_flit | output | FLIT_W | Column output flit |
| row_out_valid | output | 1 | Row output holds a flit |
| row_out_ready | input | 1 | Downstream row neighbour takes the flit |
| row_out_flit | output | FLIT_W | Row output flit |
| ej_valid | output | 1 | Ejection output holds a flit |
| ej_ready | input | 1 | Tile takes the ejected flit |
| ej_flit | output | FLIT_W | Ejected flit |

## Verification
The hardest situation to reach is a sustained contest for the row output between a turning flit and a local injection while no row-through traffic is present. Only in that case does the round-robin pointer decide anything. The stimulus holds both requests valid for several cycles, with the row output always ready. It then checks that exactly one of the two is accepted each cycle, that the winner alternates, and that each winner's flit shows up on the row output one edge later. Separate directed sequences stack all three ejection sources, and hold the row output under backpressure.

// File: rtl/mesh_yx_pkg.sv
package mesh_yx_pkg;
  typedef enum logic [1:0] {
    RT_EJECT = 2'd0,
    RT_COL   = 2'd1,
    RT_ROW   = 2'd2
  } route_e;

  localparam int NUM_OUT = 3;
  localparam int OUT_EJ  = 0;
  localparam int OUT_COL = 1;
  localparam int OUT_ROW = 2;
endpackage

// File: rtl/mesh_route_dec.sv
module mesh_route_dec
  import mesh_yx_pkg::*;
#(
  parameter int COORD_W   = 3,
  parameter int MY_X      = 0,
  parameter int MY_Y      = 0,
  parameter bit ROW_INPUT = 1'b0
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output route_e             route
);
  localparam logic [COORD_W-1:0] MX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] MY = COORD_W'(MY_Y);

  generate
    if (ROW_INPUT) begin : g_row
      // row traffic never turns back onto a column
      assign route = (dst_x == MX && dst_y == MY) ? RT_EJECT : RT_ROW;
    end else begin : g_col
      assign route = (dst_y != MY) ? RT_COL :
                     (dst_x != MX) ? RT_ROW : RT_EJECT;
    end
  endgenerate
endmodule

// File: rtl/mesh_out_reg.sv
module mesh_out_reg #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         o_ready,
  output logic         o_valid,
  output logic [W-1:0] o_data,
  output logic         can_load
);
  assign can_load = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
    end else if (can_load) begin
      o_valid <= load;
    end
  end

  always_ff @(posedge clk) begin
    if (load && can_load) begin
      o_data <= din;
    end
  end

  // R10: a stalled output keeps its flit
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> o_valid && $stable(o_data));

  // R10: the arbiters never load into a stalled output
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |-> can_load);
endmodule

// File: rtl/mesh_turn_arb.sv
module mesh_turn_arb (
  input  logic clk,
  input  logic rst,
  input  logic thru_req,
  input  logic turn_req,
  input  logic inj_req,
  input  logic can_load,
  output logic gnt_thru,
  output logic gnt_turn,
  output logic gnt_inj
);
  logic favor_inj;
  logic slot_free;

  assign slot_free = can_load && !thru_req;
  assign gnt_thru  = thru_req && can_load;
  assign gnt_turn  = slot_free && turn_req && (!inj_req || !favor_inj);
  assign gnt_inj   = slot_free && inj_req && (!turn_req || favor_inj);

  always_ff @(posedge clk) begin
    if (rst) begin
      favor_inj <= 1'b0;
    end else if (gnt_turn) begin
      favor_inj <= 1'b1;
    end else if (gnt_inj) begin
      favor_inj <= 1'b0;
    end
  end

  // R6: one winner at most per cycle
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_thru, gnt_turn, gnt_inj}));

  // R7: after a turn win under contention, the next contested slot goes to injection
  a_r7_alternate: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(turn_req && inj_req && gnt_turn) &&
    turn_req && inj_req && slot_free |-> gnt_inj);

  // R7: and the reverse
  a_r7_alternate_back: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(turn_req && inj_req && gnt_inj) &&
    turn_req && inj_req && slot_free |-> gnt_turn);
endmodule

// File: rtl/mesh_yx_router.sv
module mesh_yx_router
  import mesh_yx_pkg::*;
#(
  parameter int COORD_W   = 3,
  parameter int PAYLOAD_W = 16,
  parameter int MY_X      = 0,
  parameter int MY_Y      = 0,
  localparam int FLIT_W   = PAYLOAD_W + 2 * COORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [FLIT_W-1:0] inj_flit,
  input  logic              col_in_valid,
  output logic              col_in_ready,
  input  logic [FLIT_W-1:0] col_in_flit,
  input  logic              row_in_valid,
  output logic              row_in_ready,
  input  logic [FLIT_W-1:0] row_in_flit,
  output logic              col_out_valid,
  input  logic              col_out_ready,
  output logic [FLIT_W-1:0] col_out_flit,
  output logic              row_out_valid,
  input  logic              row_out_ready,
  output logic [FLIT_W-1:0] row_out_flit,
  output logic              ej_valid,
  input  logic              ej_ready,
  output logic [FLIT_W-1:0] ej_flit
);
  localparam int XLO = PAYLOAD_W;
  localparam int YLO = PAYLOAD_W + COORD_W;
  localparam logic [COORD_W-1:0] MX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] MY = COORD_W'(MY_Y);

  route_e r_inj, r_col, r_row;

  mesh_route_dec #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y), .ROW_INPUT(1'b0)) u_dec_inj (
    .dst_x(inj_flit[XLO +: COORD_W]), .dst_y(inj_flit[YLO +: COORD_W]), .route(r_inj));
  mesh_route_dec #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y), .ROW_INPUT(1'b0)) u_dec_col (
    .dst_x(col_in_flit[XLO +: COORD_W]), .dst_y(col_in_flit[YLO +: COORD_W]), .route(r_col));
  mesh_route_dec #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y), .ROW_INPUT(1'b1)) u_dec_row (
    .dst_x(row_in_flit[XLO +: COORD_W]), .dst_y(row_in_flit[YLO +: COORD_W]), .route(r_row));

  // requests per source and target
  logic col_thru, col_turn, col_ej, row_thru, row_ej, inj_col, inj_row, inj_ej;
  assign col_thru = col_in_valid && (r_col == RT_COL);
  assign col_turn = col_in_valid && (r_col == RT_ROW);
  assign col_ej   = col_in_valid && (r_col == RT_EJECT);
  assign row_thru = row_in_valid && (r_row == RT_ROW);
  assign row_ej   = row_in_valid && (r_row == RT_EJECT);
  assign inj_col  = inj_valid && (r_inj == RT_COL);
  assign inj_row  = inj_valid && (r_inj == RT_ROW);
  assign inj_ej   = inj_valid && (r_inj == RT_EJECT);

  // output stages
  logic [NUM_OUT-1:0] o_load, o_can, o_rdy, o_vld;
  logic [FLIT_W-1:0]  o_din [NUM_OUT];
  logic [FLIT_W-1:0]  o_q   [NUM_OUT];

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      mesh_out_reg #(.W(FLIT_W)) u_reg (
        .clk(clk), .rst(rst), .load(o_load[g]), .din(o_din[g]),
        .o_ready(o_rdy[g]), .o_valid(o_vld[g]), .o_data(o_q[g]), .can_load(o_can[g]));
    end
  endgenerate

  assign o_rdy[OUT_EJ]  = ej_ready;
  assign o_rdy[OUT_COL] = col_out_ready;
  assign o_rdy[OUT_ROW] = row_out_ready;

  assign ej_valid      = o_vld[OUT_EJ];
  assign ej_flit       = o_q[OUT_EJ];
  assign col_out_valid = o_vld[OUT_COL];
  assign col_out_flit  = o_q[OUT_COL];
  assign row_out_valid = o_vld[OUT_ROW];
  assign row_out_flit  = o_q[OUT_ROW];

  // column output: ring traffic first, injection takes idle slots
  logic g_col_thru, g_inj_col;
  assign g_col_thru = col_thru && o_can[OUT_COL];
  assign g_inj_col  = inj_col && !col_thru && o_can[OUT_COL];

  // row output: ring traffic first, then round-robin turn vs injection
  logic g_row_thru, g_turn, g_inj_row;
  mesh_turn_arb u_row_arb (
    .clk(clk), .rst(rst), .thru_req(row_thru), .turn_req(col_turn), .inj_req(inj_row),
    .can_load(o_can[OUT_ROW]), .gnt_thru(g_row_thru), .gnt_turn(g_turn), .gnt_inj(g_inj_row));

  // ejection: row, then column, then local
  logic g_row_ej, g_col_ej, g_inj_ej;
  assign g_row_ej = row_ej && o_can[OUT_EJ];
  assign g_col_ej = col_ej && !row_ej && o_can[OUT_EJ];
  assign g_inj_ej = inj_ej && !row_ej && !col_ej && o_can[OUT_EJ];

  assign o_load[OUT_COL] = g_col_thru || g_inj_col;
  assign o_din[OUT_COL]  = g_col_thru ? col_in_flit : inj_flit;
  assign o_load[OUT_ROW] = g_row_thru || g_turn || g_inj_row;
  assign o_din[OUT_ROW]  = g_row_thru ? row_in_flit : (g_turn ? col_in_flit : inj_flit);
  assign o_load[OUT_EJ]  = g_row_ej || g_col_ej || g_inj_ej;
  assign o_din[OUT_EJ]   = g_row_ej ? row_in_flit : (g_col_ej ? col_in_flit : inj_flit);

  assign col_in_ready = g_col_thru || g_turn || g_col_ej;
  assign row_in_ready = g_row_thru || g_row_ej;
  assign inj_ready    = g_inj_col || g_inj_row || g_inj_ej;

  // R2: only flits for another row use the column output
  a_r2_col_out_dest: assert property (@(posedge clk) disable iff (rst)
    col_out_valid |-> col_out_flit[YLO +: COORD_W] != MY);

  // R3: row output carries flits for this row and another column
  a_r3_row_out_dest: assert property (@(posedge clk) disable iff (rst)
    row_out_valid |-> (row_out_flit[YLO +: COORD_W] == MY) && (row_out_flit[XLO +: COORD_W] != MX));

  // R4: only flits addressed to this tile are ejected
  a_r4_eject_dest: assert property (@(posedge clk) disable iff (rst)
    ej_valid |-> (ej_flit[YLO +: COORD_W] == MY) && (ej_flit[XLO +: COORD_W] == MX));

  // R5: column ring traffic blocks a column-bound injection
  a_r5_col_first: assert property (@(posedge clk) disable iff (rst)
    col_thru && inj_col |-> !inj_ready);

  // R6: row ring traffic blocks turn and injection
  a_r6_row_first: assert property (@(posedge clk) disable iff (rst)
    row_thru && o_can[OUT_ROW] |-> row_in_ready && !(col_in_ready && col_turn) && !(inj_ready && inj_row));

  // R8: row ejection beats the others
  a_r8_eject_order: assert property (@(posedge clk) disable iff (rst)
    row_ej && o_can[OUT_EJ] |-> row_in_ready && !(col_in_ready && col_ej) && !(inj_ready && inj_ej));
endmodule

// File: tb/mesh_yx_router_bench.sv
`timescale 1ns/1ps
module mesh_yx_router_bench;
  localparam int CW = 3;
  localparam int PW = 16;
  localparam int FW = PW + 2 * CW;
  localparam int NX = 2;
  localparam int NY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic inj_valid, col_in_valid, row_in_valid;
  logic inj_ready, col_in_ready, row_in_ready;
  logic [FW-1:0] inj_flit, col_in_flit, row_in_flit;
  logic col_out_valid, row_out_valid, ej_valid;
  logic col_out_ready, row_out_ready, ej_ready;
  logic [FW-1:0] col_out_flit, row_out_flit, ej_flit;

  mesh_yx_router #(.COORD_W(CW), .PAYLOAD_W(PW), .MY_X(NX), .MY_Y(NY)) u_mesh_yx_router (
    .clk(clk), .rst(rst),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_flit(inj_flit),
    .col_in_valid(col_in_valid), .col_in_ready(col_in_ready), .col_in_flit(col_in_flit),
    .row_in_valid(row_in_valid), .row_in_ready(row_in_ready), .row_in_flit(row_in_flit),
    .col_out_valid(col_out_valid), .col_out_ready(col_out_ready), .col_out_flit(col_out_flit),
    .row_out_valid(row_out_valid), .row_out_ready(row_out_ready), .row_out_flit(row_out_flit),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_flit(ej_flit));

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  function automatic logic [FW-1:0] mk(input int x, input int y, input int p);
    return {CW'(y), CW'(x), PW'(p)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    inj_valid = 1'b0; col_in_valid = 1'b0; row_in_valid = 1'b0;
    inj_flit = '0; col_in_flit = '0; row_in_flit = '0;
  endtask

  // vector: {src[1:0], dst_x[2:0], dst_y[2:0], out[1:0]}
  // src 0=local 1=column 2=row ; out 0=eject 1=column 2=row
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 3'd2, 3'd3, 2'd0},  // R2 own tile
    {2'd0, 3'd2, 3'd5, 2'd1},  // R2 other row
    {2'd0, 3'd4, 3'd3, 2'd2},  // R2 same row other column
    {2'd0, 3'd0, 3'd0, 2'd1},  // R2 other row and column
    {2'd1, 3'd2, 3'd1, 2'd1},  // R3 through
    {2'd1, 3'd5, 3'd3, 2'd2},  // R3 turn
    {2'd1, 3'd2, 3'd3, 2'd0},  // R3 eject
    {2'd2, 3'd4, 3'd3, 2'd2},  // R4 through
    {2'd2, 3'd2, 3'd3, 2'd0},  // R4 eject
    {2'd1, 3'd0, 3'd7, 2'd1}   // R3 through, far row
  };

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa, fb, fc;
    int prev_w;
    idle_inputs();
    col_out_ready = 1'b1; row_out_ready = 1'b1; ej_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 col_out_valid during reset", 32'(col_out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 col_out_valid after reset", 32'(col_out_valid), 0);
    check("R1 row_out_valid after reset", 32'(row_out_valid), 0);
    check("R1 ej_valid after reset", 32'(ej_valid), 0);

    // table walk: R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0] src, op;
      logic [FW-1:0] f;
      logic [2:0] vld;
      logic [FW-1:0] got;
      src = VEC[i][9:8];
      op  = VEC[i][1:0];
      f   = mk(int'(VEC[i][7:5]), int'(VEC[i][4:2]), 16'hA000 + i);
      @(negedge clk);
      case (src)
        2'd0: begin inj_valid = 1'b1; inj_flit = f; end
        2'd1: begin col_in_valid = 1'b1; col_in_flit = f; end
        default: begin row_in_valid = 1'b1; row_in_flit = f; end
      endcase
      #1;
      check($sformatf("R2/R3/R4 vec%0d source ready", i),
            32'(src == 0 ? inj_ready : (src == 1 ? col_in_ready : row_in_ready)), 1);
      vld = {row_out_valid, col_out_valid, ej_valid};
      check($sformatf("R9 vec%0d nothing before edge", i), 32'(vld), 0);
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      vld = {row_out_valid, col_out_valid, ej_valid};
      check($sformatf("R2/R3/R4 vec%0d output select", i), 32'(vld), 32'(3'b001 << op));
      got = (op == 0) ? ej_flit : ((op == 1) ? col_out_flit : row_out_flit);
      check($sformatf("R9 vec%0d flit", i), 32'(got), 32'(f));
    end
    @(negedge clk);

    // R5: column ring traffic beats injection to the column
    fa = mk(2, 6, 16'h5151); fb = mk(2, 0, 16'h5252);
    col_in_valid = 1'b1; col_in_flit = fa; inj_valid = 1'b1; inj_flit = fb;
    #1;
    check("R5 column accepted", 32'(col_in_ready), 1);
    check("R5 injection held", 32'(inj_ready), 0);
    @(posedge clk); @(negedge clk);
    check("R5 column flit out first", 32'(col_out_flit), 32'(fa));
    col_in_valid = 1'b0;
    #1;
    check("R5 injection proceeds", 32'(inj_ready), 1);
    @(posedge clk); @(negedge clk);
    check("R5 injected flit out", 32'(col_out_flit), 32'(fb));
    idle_inputs();
    @(negedge clk);

    // R6: row ring traffic beats turn and injection
    fa = mk(5, 3, 16'h6161); fb = mk(6, 3, 16'h6262); fc = mk(0, 3, 16'h6363);
    row_in_valid = 1'b1; row_in_flit = fa;
    col_in_valid = 1'b1; col_in_flit = fb;
    inj_valid = 1'b1; inj_flit = fc;
    #1;
    check("R6 ready {row,col,inj}", 32'({row_in_ready, col_in_ready, inj_ready}), 32'(3'b100));
    @(posedge clk); @(negedge clk);
    check("R6 row flit out", 32'(row_out_flit), 32'(fa));
    idle_inputs();
    @(negedge clk);

    // R7: turn vs injection alternate
    fa = mk(6, 3, 16'h7171); fb = mk(1, 3, 16'h7272);
    col_in_valid = 1'b1; col_in_flit = fa; inj_valid = 1'b1; inj_flit = fb;
    prev_w = -1;
    for (int k = 0; k < 5; k++) begin
      int w;
      #1;
      check($sformatf("R7 one winner cycle %0d", k), 32'(col_in_ready ^ inj_ready), 1);
      w = col_in_ready ? 0 : 1;
      if (k > 0) begin
        check($sformatf("R7 alternation cycle %0d", k), 32'(w != prev_w), 1);
        check($sformatf("R7 previous winner on row cycle %0d", k),
              32'(row_out_flit), 32'(prev_w == 0 ? fa : fb));
      end
      prev_w = w;
      @(posedge clk); @(negedge clk);
    end
    idle_inputs();
    @(negedge clk);

    // R10: backpressure on the row output
    fa = mk(4, 3, 16'hA1A1); fb = mk(4, 3, 16'hA2A2);
    row_out_ready = 1'b0;
    row_in_valid = 1'b1; row_in_flit = fa;
    @(posedge clk); @(negedge clk);
    row_in_flit = fb;
    #1;
    check("R10 no accept while stalled", 32'(row_in_ready), 0);
    check("R10 stalled flit", 32'(row_out_flit), 32'(fa));
    @(posedge clk); @(negedge clk);
    check("R10 flit held", 32'(row_out_flit), 32'(fa));
    check("R10 still valid", 32'(row_out_valid), 1);
    row_out_ready = 1'b1;
    #1;
    check("R10 accept once draining", 32'(row_in_ready), 1);
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R10 next flit after drain", 32'(row_out_flit), 32'(fb));
    @(negedge clk);

    // R8: ejection order
    fa = mk(2, 3, 16'h8181); fb = mk(2, 3, 16'h8282); fc = mk(2, 3, 16'h8383);
    row_in_valid = 1'b1; row_in_flit = fa;
    col_in_valid = 1'b1; col_in_flit = fb;
    inj_valid = 1'b1; inj_flit = fc;
    #1;
    check("R8 row ejects first", 32'({row_in_ready, col_in_ready, inj_ready}), 32'(3'b100));
    @(posedge clk); @(negedge clk);
    check("R8 row flit ejected", 32'(ej_flit), 32'(fa));
    row_in_valid = 1'b0;
    #1;
    check("R8 column ejects second", 32'({row_in_ready, col_in_ready, inj_ready}), 32'(3'b010));
    @(posedge clk); @(negedge clk);
    check("R8 column flit ejected", 32'(ej_flit), 32'(fb));
    col_in_valid = 1'b0;
    #1;
    check("R8 local ejects last", 32'({row_in_ready, col_in_ready, inj_ready}), 32'(3'b001));
    @(posedge clk); @(negedge clk);
    check("R8 local flit ejected", 32'(ej_flit), 32'(fc));
    idle_inputs();
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule